// File: doc/BRIEF.md
# Wait / DMA Request Line Controller

This block drives the shared wait-or-request handshake line of one serial channel. The line is active low and can float. It carries one of two protocols. As a CPU wait line it normally floats. It is pulled low while the CPU strobes a data access that the channel cannot yet accept or supply. As a DMA request line it idles driven high. It goes low once the channel is ready to move a byte, and it returns high after the access that services it.

Three control bits select the behaviour:

- an enable;
- a function select (0 = wait, 1 = request);
- a direction select (0 = transmit side, 1 = receive side).

The floating state is modelled as the output enable deasserted. The pin value is then held at 1.

A second, always-driven, active-low transmit request output lets both directions run under DMA at once. When the shared line serves the receive side in request mode, this second output serves the transmit side.

Top module: `wrq_ctrl`

## Requirements
- R1: With the enable bit 0 and function select 1, the line is driven (`wrq_oe_o`=1) high (`wrq_n_o`=1).
- R2: With the enable bit 0 and function select 0, the line floats (`wrq_oe_o`=0, `wrq_n_o` held at 1).
- R3: Wait mode, direction 0: the line is driven low in the same cycle that `cpu_wr` is 1 while `tx_empty` is 0. Otherwise it floats.
- R4: Wait mode, direction 1: the line is driven low in the same cycle that `cpu_rd` is 1 while `rx_avail` is 0. Otherwise it floats. Wait mode never drives the line high.
- R5: Request mode: the line is always driven. It goes low one clock after the ready condition is seen without a servicing access. The ready condition is `tx_empty` for direction 0 and `rx_avail` for direction 1.
- R6: Request mode: the line returns high at the clock edge after the servicing access. The servicing access is `cpu_wr` for direction 0 and `cpu_rd` for direction 1.
- R7: After a servicing access the request stays high while the ready condition stays true. It re-asserts only after the ready condition has been seen false and then true again.
- R8: `txreq_n_o` asserts (low) one clock after `tx_empty` is seen with enable=1, function=1 and direction=1. It follows the R6/R7 service rules using `cpu_wr`. In every other configuration it is driven high.
- R9: During and after reset, with enable 0, no request is pending: `txreq_n_o`=1, and the line is high or floating according to R1/R2. Clearing the enable or function bit drops a pending request at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Line function enable |
| cfg_req_mode | input | 1 | 0 = CPU wait, 1 = DMA request |
| cfg_rx_dir | input | 1 | 0 = transmit side, 1 = receive side |
| tx_empty | input | 1 | Transmit buffer can accept a byte |
| rx_avail | input | 1 | Received byte is available |
| cpu_rd | input | 1 | Data read strobe (CPU or DMA) |
| cpu_wr | input | 1 | Data write strobe (CPU or DMA) |
| wrq_n_o | output | 1 | Shared line value, active low |
| wrq_oe_o | output | 1 | Shared line drive enable (0 = floating) |
| txreq_n_o | output | 1 | Dedicated transmit request, active low |

## Verification
The assertions assume the configuration bits and status inputs change only between clock edges and are stable around the sampling edge. They also assume a servicing strobe lasts at least one clock. The bench meets this by driving every input on the falling edge, and it holds each strobe for whole cycles. The sweep visits every combination of the seven inputs. Each combination starts from a cleared request state, made by an idle cycle with the enable at 0. Directed sequences then walk the service and re-arm order for both request outputs.

// File: rtl/wrq_pkg.sv
package wrq_pkg;
   typedef enum logic {
      WRQ_FN_WAIT = 1'b0,
      WRQ_FN_REQ  = 1'b1
   } wrq_fn_e;

   typedef enum logic {
      WRQ_DIR_TX = 1'b0,
      WRQ_DIR_RX = 1'b1
   } wrq_dir_e;

   typedef struct packed {
      logic ready;
      logic access;
   } wrq_side_t;
endpackage

// File: rtl/wrq_side_sel.sv
module wrq_side_sel
   import wrq_pkg::*;
(
   input  wrq_dir_e  dir_i,
   input  logic      tx_empty_i,
   input  logic      rx_avail_i,
   input  logic      rd_i,
   input  logic      wr_i,
   output wrq_side_t side_o
);
   always_comb begin
      if (dir_i == WRQ_DIR_RX) begin
         side_o.ready  = rx_avail_i;
         side_o.access = rd_i;
      end else begin
         side_o.ready  = tx_empty_i;
         side_o.access = wr_i;
      end
   end
endmodule

// File: rtl/wrq_req_track.sv
module wrq_req_track
   import wrq_pkg::*;
#(
   parameter int REARM_NEEDS_IDLE = 1
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      active_i,
   input  wrq_side_t side_i,
   output logic      req_o
);
   if (REARM_NEEDS_IDLE < 0 || REARM_NEEDS_IDLE > 1) begin : g_bad_rearm
      $error("wrq_req_track: REARM_NEEDS_IDLE must be 0 or 1");
   end

   logic served_q;
   logic served_d;
   logic req_d;

   generate
      if (REARM_NEEDS_IDLE == 1) begin : g_hold
         always_comb begin
            if (!active_i)           served_d = 1'b0;
            else if (side_i.access)  served_d = 1'b1;
            else if (!side_i.ready)  served_d = 1'b0;
            else                     served_d = served_q;
         end
      end else begin : g_nohold
         always_comb served_d = 1'b0;
      end
   endgenerate

   always_comb req_d = active_i & side_i.ready & ~side_i.access & ~served_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         served_q <= 1'b0;
         req_o    <= 1'b0;
      end else begin
         served_q <= served_d;
         req_o    <= req_d;
      end
   end

   AST_REQ_DROPS_ON_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
      (req_o && side_i.access) |=> !req_o); // R6

   AST_REQ_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req_o) |-> $past(side_i.ready)); // R5

   AST_NO_QUICK_REARM: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(side_i.access) && $past(active_i) && $past(side_i.ready) && side_i.ready && active_i)
      |=> !req_o); // R7

   AST_IDLE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      !active_i |=> !req_o); // R9
endmodule

// File: rtl/wrq_pin_drv.sv
module wrq_pin_drv
   import wrq_pkg::*;
#(
   parameter int WAIT_REG = 0
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    en_i,
   input  wrq_fn_e fn_i,
   input  logic    wait_hit_i,
   input  logic    req_i,
   output logic    pin_n_o,
   output logic    pin_oe_o
);
   if (WAIT_REG < 0 || WAIT_REG > 1) begin : g_bad_wait
      $error("wrq_pin_drv: WAIT_REG must be 0 or 1");
   end

   logic wait_low;

   generate
      if (WAIT_REG == 1) begin : g_wait_ff
         logic wait_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) wait_q <= 1'b0;
            else        wait_q <= en_i & wait_hit_i & (fn_i == WRQ_FN_WAIT);
         end
         assign wait_low = wait_q & en_i & (fn_i == WRQ_FN_WAIT);
      end else begin : g_wait_comb
         assign wait_low = en_i & wait_hit_i & (fn_i == WRQ_FN_WAIT);
      end
   endgenerate

   always_comb begin
      if (fn_i == WRQ_FN_REQ) begin
         pin_oe_o = 1'b1;
         pin_n_o  = ~(en_i & req_i);
      end else begin
         pin_oe_o = wait_low;
         pin_n_o  = ~wait_low;
      end
   end

   AST_DIS_REQ_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_i && fn_i == WRQ_FN_REQ) |-> (pin_oe_o && pin_n_o)); // R1

   AST_DIS_WAIT_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_i && fn_i == WRQ_FN_WAIT) |-> !pin_oe_o); // R2

   AST_WAIT_NEVER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (fn_i == WRQ_FN_WAIT && pin_oe_o) |-> !pin_n_o); // R4

   AST_REQ_ALWAYS_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
      (fn_i == WRQ_FN_REQ) |-> pin_oe_o); // R5
endmodule

// File: rtl/wrq_ctrl.sv
module wrq_ctrl
   import wrq_pkg::*;
#(
   parameter int WAIT_REG         = 0,
   parameter int REARM_NEEDS_IDLE = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cfg_en,
   input  logic cfg_req_mode,
   input  logic cfg_rx_dir,
   input  logic tx_empty,
   input  logic rx_avail,
   input  logic cpu_rd,
   input  logic cpu_wr,
   output logic wrq_n_o,
   output logic wrq_oe_o,
   output logic txreq_n_o
);
   localparam int NUM_TRACK = 2;

   wrq_fn_e   fn;
   wrq_dir_e  dir;
   wrq_side_t main_side;
   wrq_side_t tx_side;
   logic      wait_hit;
   logic [NUM_TRACK-1:0] trk_active;
   logic [NUM_TRACK-1:0] trk_req;
   wrq_side_t trk_side [NUM_TRACK];

   assign fn  = wrq_fn_e'(cfg_req_mode);
   assign dir = wrq_dir_e'(cfg_rx_dir);

   wrq_side_sel u_main_sel (
      .dir_i      (dir),
      .tx_empty_i (tx_empty),
      .rx_avail_i (rx_avail),
      .rd_i       (cpu_rd),
      .wr_i       (cpu_wr),
      .side_o     (main_side)
   );

   wrq_side_sel u_tx_sel (
      .dir_i      (WRQ_DIR_TX),
      .tx_empty_i (tx_empty),
      .rx_avail_i (rx_avail),
      .rd_i       (cpu_rd),
      .wr_i       (cpu_wr),
      .side_o     (tx_side)
   );

   assign wait_hit = main_side.access & ~main_side.ready;

   assign trk_active[0] = cfg_en & (fn == WRQ_FN_REQ);
   assign trk_active[1] = cfg_en & (fn == WRQ_FN_REQ) & (dir == WRQ_DIR_RX);
   assign trk_side[0]   = main_side;
   assign trk_side[1]   = tx_side;

   for (genvar i = 0; i < NUM_TRACK; i++) begin : g_trk
      wrq_req_track #(.REARM_NEEDS_IDLE(REARM_NEEDS_IDLE)) u_trk (
         .clk      (clk),
         .rst_n    (rst_n),
         .active_i (trk_active[i]),
         .side_i   (trk_side[i]),
         .req_o    (trk_req[i])
      );
   end

   wrq_pin_drv #(.WAIT_REG(WAIT_REG)) u_pin (
      .clk        (clk),
      .rst_n      (rst_n),
      .en_i       (cfg_en),
      .fn_i       (fn),
      .wait_hit_i (wait_hit),
      .req_i      (trk_req[0]),
      .pin_n_o    (wrq_n_o),
      .pin_oe_o   (wrq_oe_o)
   );

   assign txreq_n_o = ~trk_req[1];

   AST_TXREQ_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg_en && cfg_req_mode && cfg_rx_dir) |=> txreq_n_o); // R8

   AST_FLOAT_VALUE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      !wrq_oe_o |-> wrq_n_o); // R2
endmodule

// File: tb/tb_wrq_ctrl.sv
`timescale 1ns/1ps
module tb_wrq_ctrl;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_en = 0, cfg_req_mode = 0, cfg_rx_dir = 0;
   logic tx_empty = 0, rx_avail = 0, cpu_rd = 0, cpu_wr = 0;
   logic wrq_n_o, wrq_oe_o, txreq_n_o;
   int checks = 0;
   int fails = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   wrq_ctrl dut (
      .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_req_mode(cfg_req_mode),
      .cfg_rx_dir(cfg_rx_dir), .tx_empty(tx_empty), .rx_avail(rx_avail),
      .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .wrq_n_o(wrq_n_o), .wrq_oe_o(wrq_oe_o),
      .txreq_n_o(txreq_n_o)
   );

   task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s act{n,oe,tx}=%b exp=%b t=%0t", req, act, exp, $time);
      end
   endtask

   task automatic setv(input logic [6:0] v);
      {cfg_en, cfg_req_mode, cfg_rx_dir, tx_empty, rx_avail, cpu_rd, cpu_wr} = v;
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      logic en, fn, dir, txe, rxa, rd, wr, wt, rq, ready, acc;
      logic [2:0] exp;
      @(negedge clk);
      chk("R9 in reset", {wrq_n_o, wrq_oe_o, txreq_n_o}, 3'b101);
      step();
      rst_n = 1'b1;
      step();
      chk("R9 after reset", {wrq_n_o, wrq_oe_o, txreq_n_o}, 3'b101);

      // exhaustive sweep, each combination from a cleared state: R1 R2 R3 R4 R5 R8
      for (int c = 0; c < 128; c++) begin
         setv(7'd0);
         step();
         setv(c[6:0]);
         {en, fn, dir, txe, rxa, rd, wr} = c[6:0];
         ready = dir ? rxa : txe;
         acc   = dir ? rd : wr;
         #1;
         wt = en & ~fn & acc & ~ready;
         if (fn) exp = 3'b111;
         else    exp = {1'b1, wt, 1'b1};
         if (wt) exp[2] = 1'b0;
         chk(fn ? (en ? "R5 pre-edge" : "R1") : (en ? (dir ? "R4" : "R3") : "R2"),
             {wrq_n_o, wrq_oe_o, txreq_n_o}, exp);
         step();
         rq = en & fn & ready & ~acc;
         exp[2] = fn ? ~rq : ~wt;
         exp[1] = fn ? 1'b1 : wt;
         exp[0] = ~(en & fn & dir & txe & ~wr);
         chk(fn ? "R5 R8 sweep" : "R3 R4 sweep", {wrq_n_o, wrq_oe_o, txreq_n_o}, exp);
      end

      // transmit request sequence: R5 R6 R7
      setv(7'b1100000); step();
      tx_empty = 1; step();
      chk("R5 tx ready", {wrq_n_o, wrq_oe_o, txreq_n_o}, 3'b011);
      cpu_wr = 1; step();
      cpu_wr = 0;
      chk("R6 write serviced", {wrq_n_o, wrq_oe_o, txreq_n_o}, 3'b111);
      step(); step();
      chk("R7 no rearm while ready held", {wrq_n_o, wrq_oe_o, txreq_n_o}, 3'b111);
      tx_empty = 0; step();
      chk("R7 ready false", {wrq_n_o, wrq_oe_o, txreq_n_o}, 3'b111);
      tx_empty = 1; step();
      chk("R7 rearm", {wrq_n_o, wrq_oe_o, txreq_n_o}, 3'b011);
      cfg_en = 0; step();
      chk("R9 enable cleared drops", {wrq_n_o, wrq_oe_o, txreq_n_o}, 3'b111);

      // full duplex: line on receive side, dedicated tx request: R8 R6 R7
      setv(7'b1110000); step();
      rx_avail = 1; tx_empty = 1; step();
      chk("R8 both requests", {wrq_n_o, wrq_oe_o, txreq_n_o}, 3'b010);
      cpu_rd = 1; step();
      cpu_rd = 0;
      chk("R6 read serviced", {wrq_n_o, wrq_oe_o, txreq_n_o}, 3'b110);
      cpu_wr = 1; step();
      cpu_wr = 0;
      chk("R8 tx request serviced", {wrq_n_o, wrq_oe_o, txreq_n_o}, 3'b111);
      step();
      chk("R7 both held off", {wrq_n_o, wrq_oe_o, txreq_n_o}, 3'b111);
      tx_empty = 0; rx_avail = 0; step();
      tx_empty = 1; step();
      chk("R8 tx rearm only", {wrq_n_o, wrq_oe_o, txreq_n_o}, 3'b110);
      rx_avail = 1; step();
      chk("R7 rx rearm", {wrq_n_o, wrq_oe_o, txreq_n_o}, 3'b010);
      cfg_req_mode = 0; #1;
      chk("R9 function cleared", {wrq_n_o, wrq_oe_o, txreq_n_o}, 3'b100);
      step();
      chk("R9 function cleared edge", {wrq_n_o, wrq_oe_o, txreq_n_o}, 3'b101);
      done = 1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (5000) @(posedge clk);
            checks++; fails++;
            $display("FAIL watchdog act=hung exp=done");
         end
      join_any
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule